// File: doc/BRIEF.md
# Single-Wire Battery-Monitor Bus Master

This block is a memory-mapped master for a single-wire, open-drain serial bus of the kind used to reach battery fuel-gauge chips. Software writes a byte into a transmit register and sets a start flag. The controller then sends the byte as eight timed low pulses, least significant bit first. It can also collect a byte that the slave returns as eight low pulses, or drive a long break pulse that resets the slave's interface. A completion interrupt marks the end of a transmit, a receive, or a break or receive timeout.

A normal bus transaction is two operations issued back to back. The first is a command byte, with bit 7 set for a write and clear for a read and the slave's register address in bits 6:0. The second is either a data transmit or a receive. All bit timing is derived from the functional clock through the parameter `CLK_PER_US`, and every pulse length is a parameter in microseconds. A soft reset returns the register state to its reset values and stops any transfer. A status bit reports when that reset has finished.

Top module: `swbus_master`

## Requirements
- R1: After reset, control (0x0C), interrupt status (0x10), transmit data (0x04) and receive data (0x08) read 0, `irq` is 0 and `line_pull` is 0. System status (0x18) bit 0 reads 0 for `RST_CYCLES` cycles after reset and reads 1 after that.
- R2: The register at offset 0x00 reads `REV_MAJOR` in bits 7:4 and `REV_MINOR` in bits 3:0, which is 0x12 with the default parameters.
- R3: A control write with start (bit 4) = 1, direction (bit 1) = 0 and clock enable (bit 5) = 1 sends the transmit-data byte LSB first. Each bit is a low pulse of `ONE_LOW_US` for a 1 or `ZERO_LOW_US` for a 0, inside a cell of `CELL_US`. At the end, interrupt-status bit 2 is set and the start bit reads 0.
- R4: A start with direction = 1 receives a byte LSB first. For each bit the controller waits for a falling edge from the slave and samples the line `SAMPLE_US` later, where high means 1. The byte is stored in receive data and interrupt-status bit 1 is set. The start bit then reads 0. The controller never pulls the line during a receive.
- R5: If no slave falling edge arrives within `RX_WINDOW_US`, the receive ends with interrupt-status bit 0 set and bit 1 clear, and the start bit reads 0.
- R6: A start with break (bit 2) = 1 pulls the line low for `BREAK_LOW_US` and then releases it for `BREAK_REC_US`. Interrupt-status bit 0 is then set, and both the break bit and the start bit read 0.
- R7: A read of interrupt status returns its bits and clears all of them. A completion event in the same cycle as the read is kept.
- R8: `irq` is 1 exactly when interrupt enable (control bit 6) is 1 and any interrupt-status bit is 1. With interrupt enable at 0, status still records the event.
- R9: A start written with clock enable = 0 is ignored: the start bit stays 0, the line is not pulled and no status bit is set.
- R10: Control writes made while the start bit reads 1 are ignored. The control readback is unchanged and the running transfer is neither restarted nor altered.
- R11: Writing system configuration (0x14) bit 1 = 1 starts a soft reset. The soft-reset bit reads 1 and system status bit 0 reads 0 for `RST_CYCLES` cycles. The soft reset stops any transfer and releases the line. Control, status and data registers return to 0, and the auto-idle bit (0x14 bit 0) takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears interrupt status when addressed) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Completion interrupt |
| line_in | input | 1 | Sensed level of the bus line |
| line_pull | output | 1 | 1 pulls the open-drain line low |

## Verification
The bench measures every low pulse on the line in clock cycles, which catches a swapped 1/0 pulse length, an off-by-one counter load or MSB-first shifting. A loopback slave returns a byte with the pulse widths of both bit values, so a sample point placed on the wrong side of a short pulse shows up as wrong data. The bench checks the timeout both before and after the window ends: a design that fires early or never fires fails. It also checks that a control write during a transfer, a start without clock enable, and a soft reset in the middle of a byte leave the readback, the line and the status registers exactly as required. A design that restarts, misses a clear or keeps stale receive data is reported.

// File: rtl/swbus_pkg.sv
package swbus_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_BRK_LOW,
        SQ_BRK_REC,
        SQ_TX_LOW,
        SQ_TX_HIGH,
        SQ_RX_FALL,
        SQ_RX_SAMP,
        SQ_RX_RISE
    } sq_state_e;

    typedef enum logic [1:0] {
        OP_TX,
        OP_RX,
        OP_BRK
    } op_e;

    localparam logic [4:0] OFS_REV    = 5'h00;
    localparam logic [4:0] OFS_TX     = 5'h04;
    localparam logic [4:0] OFS_RX     = 5'h08;
    localparam logic [4:0] OFS_CTRL   = 5'h0C;
    localparam logic [4:0] OFS_INT    = 5'h10;
    localparam logic [4:0] OFS_SYSCFG = 5'h14;
    localparam logic [4:0] OFS_SYSST  = 5'h18;

    localparam int CB_MODE  = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_INIT  = 2;
    localparam int CB_GO    = 4;
    localparam int CB_CLKEN = 5;
    localparam int CB_IE    = 6;

    localparam int IB_TO = 0;
    localparam int IB_RX = 1;
    localparam int IB_TX = 2;

endpackage

// File: rtl/swbus_sync.sv
module swbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/swbus_seq.sv
module swbus_seq
    import swbus_pkg::*;
#(
    parameter int CLK_PER_US   = 100,
    parameter int BREAK_LOW_US = 190,
    parameter int BREAK_REC_US = 40,
    parameter int CELL_US      = 200,
    parameter int ONE_LOW_US   = 30,
    parameter int ZERO_LOW_US  = 130,
    parameter int SAMPLE_US    = 80,
    parameter int RX_WINDOW_US = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       start,
    input  op_e        op,
    input  logic [7:0] tx_byte,
    input  logic       line_s,
    output logic       pull,
    output logic       busy,
    output logic       done_tx,
    output logic       done_rx,
    output logic       done_to,
    output logic [7:0] rx_byte
);
    localparam int T_BRK  = BREAK_LOW_US * CLK_PER_US;
    localparam int T_REC  = BREAK_REC_US * CLK_PER_US;
    localparam int T_ONE  = ONE_LOW_US * CLK_PER_US;
    localparam int T_ZERO = ZERO_LOW_US * CLK_PER_US;
    localparam int T_HI1  = (CELL_US - ONE_LOW_US) * CLK_PER_US;
    localparam int T_HI0  = (CELL_US - ZERO_LOW_US) * CLK_PER_US;
    localparam int T_SAMP = SAMPLE_US * CLK_PER_US;
    localparam int T_WIN  = RX_WINDOW_US * CLK_PER_US;
    localparam int T_MAX  = (T_WIN > T_BRK) ? T_WIN : T_BRK;
    localparam int CW     = $clog2(T_MAX + 1);

    localparam logic [CW-1:0] L_BRK  = CW'(T_BRK - 1);
    localparam logic [CW-1:0] L_REC  = CW'(T_REC - 1);
    localparam logic [CW-1:0] L_ONE  = CW'(T_ONE - 1);
    localparam logic [CW-1:0] L_ZERO = CW'(T_ZERO - 1);
    localparam logic [CW-1:0] L_HI1  = CW'(T_HI1 - 1);
    localparam logic [CW-1:0] L_HI0  = CW'(T_HI0 - 1);
    localparam logic [CW-1:0] L_SAMP = CW'(T_SAMP - 1);
    localparam logic [CW-1:0] L_WIN  = CW'(T_WIN - 1);

    typedef struct packed {
        sq_state_e       state;
        logic [CW-1:0]   cnt;
        logic [3:0]      bits;
        logic [7:0]      sh;
    } seq_t;

    seq_t s_d, s_q;
    logic cnt_zero;

    assign cnt_zero = (s_q.cnt == '0);

    always_comb begin
        s_d     = s_q;
        done_tx = 1'b0;
        done_rx = 1'b0;
        done_to = 1'b0;
        if (clr) begin
            s_d = '{state: SQ_IDLE, cnt: '0, bits: '0, sh: '0};
        end else if (s_q.state == SQ_IDLE) begin
            if (start) begin
                s_d.bits = '0;
                unique case (op)
                    OP_TX: begin
                        s_d.state = SQ_TX_LOW;
                        s_d.cnt   = tx_byte[0] ? L_ONE : L_ZERO;
                        s_d.sh    = tx_byte;
                    end
                    OP_RX: begin
                        s_d.state = SQ_RX_FALL;
                        s_d.cnt   = L_WIN;
                        s_d.sh    = '0;
                    end
                    default: begin
                        s_d.state = SQ_BRK_LOW;
                        s_d.cnt   = L_BRK;
                    end
                endcase
            end
        end else if (en) begin
            s_d.cnt = s_q.cnt - 1'b1;
            unique case (s_q.state)
                SQ_BRK_LOW: if (cnt_zero) begin
                    s_d.state = SQ_BRK_REC;
                    s_d.cnt   = L_REC;
                end
                SQ_BRK_REC: if (cnt_zero) begin
                    s_d.state = SQ_IDLE;
                    done_to   = 1'b1;
                end
                SQ_TX_LOW: if (cnt_zero) begin
                    s_d.state = SQ_TX_HIGH;
                    s_d.cnt   = s_q.sh[0] ? L_HI1 : L_HI0;
                end
                SQ_TX_HIGH: if (cnt_zero) begin
                    if (s_q.bits == 4'd7) begin
                        s_d.state = SQ_IDLE;
                        done_tx   = 1'b1;
                    end else begin
                        s_d.state = SQ_TX_LOW;
                        s_d.bits  = s_q.bits + 1'b1;
                        s_d.sh    = {1'b0, s_q.sh[7:1]};
                        s_d.cnt   = s_q.sh[1] ? L_ONE : L_ZERO;
                    end
                end
                SQ_RX_FALL: begin
                    if (!line_s) begin
                        s_d.state = SQ_RX_SAMP;
                        s_d.cnt   = L_SAMP;
                    end else if (cnt_zero) begin
                        s_d.state = SQ_IDLE;
                        done_to   = 1'b1;
                    end
                end
                SQ_RX_SAMP: if (cnt_zero) begin
                    s_d.state = SQ_RX_RISE;
                    s_d.sh    = {line_s, s_q.sh[7:1]};
                    s_d.bits  = s_q.bits + 1'b1;
                    s_d.cnt   = L_WIN;
                end
                SQ_RX_RISE: begin
                    if (line_s) begin
                        if (s_q.bits == 4'd8) begin
                            s_d.state = SQ_IDLE;
                            done_rx   = 1'b1;
                        end else begin
                            s_d.state = SQ_RX_FALL;
                            s_d.cnt   = L_WIN;
                        end
                    end else if (cnt_zero) begin
                        s_d.state = SQ_IDLE;
                        done_to   = 1'b1;
                    end
                end
                default: s_d.state = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: SQ_IDLE, cnt: '0, bits: '0, sh: '0};
        else        s_q <= s_d;
    end

    assign pull    = (s_q.state == SQ_TX_LOW) || (s_q.state == SQ_BRK_LOW);
    assign busy    = (s_q.state != SQ_IDLE);
    assign rx_byte = s_q.sh;

    assert_one_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_tx, done_rx, done_to}));

    assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (s_q.state == SQ_IDLE));

    assert_rx_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_rx |-> (s_q.bits == 4'd8));
endmodule

// File: rtl/swbus_regs.sv
module swbus_regs
    import swbus_pkg::*;
#(
    parameter int REV_MAJOR  = 1,
    parameter int REV_MINOR  = 2,
    parameter int RST_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       start,
    output op_e        op,
    output logic [7:0] tx_byte,
    output logic       clken,
    output logic       clr,
    input  logic       busy,
    input  logic       done_tx,
    input  logic       done_rx,
    input  logic       done_to,
    input  logic [7:0] rx_byte
);
    localparam int RW = $clog2(RST_CYCLES + 1);
    localparam logic [RW-1:0] RST_LOAD = RW'(RST_CYCLES);

    typedef struct packed {
        logic          mode;
        logic          dir;
        logic          init;
        logic          go;
        logic          clken;
        logic          ie;
        logic [7:0]    tx;
        logic [7:0]    rx;
        logic [2:0]    ist;
        logic          autoidle;
        logic [RW-1:0] srst_cnt;
    } regs_t;

    localparam regs_t REGS_RST = '{mode: 1'b0, dir: 1'b0, init: 1'b0, go: 1'b0,
                                   clken: 1'b0, ie: 1'b0, tx: '0, rx: '0, ist: '0,
                                   autoidle: 1'b0, srst_cnt: RST_LOAD};

    regs_t r_d, r_q;
    logic  in_reset;
    logic  srst_req;
    logic  wr_syscfg;

    assign in_reset  = (r_q.srst_cnt != '0);
    assign wr_syscfg = reg_wr && (reg_addr == OFS_SYSCFG);

    always_comb begin
        r_d      = r_q;
        start    = 1'b0;
        op       = OP_TX;
        srst_req = 1'b0;
        if (in_reset) begin
            r_d.srst_cnt = r_q.srst_cnt - 1'b1;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    OFS_TX: r_d.tx = reg_wdata;
                    OFS_CTRL: if (!r_q.go) begin
                        r_d.mode  = reg_wdata[CB_MODE];
                        r_d.dir   = reg_wdata[CB_DIR];
                        r_d.clken = reg_wdata[CB_CLKEN];
                        r_d.ie    = reg_wdata[CB_IE];
                        if (reg_wdata[CB_GO] && reg_wdata[CB_CLKEN]) begin
                            r_d.go   = 1'b1;
                            r_d.init = reg_wdata[CB_INIT];
                            start    = 1'b1;
                            op       = reg_wdata[CB_INIT] ? OP_BRK :
                                       (reg_wdata[CB_DIR] ? OP_RX : OP_TX);
                        end
                    end
                    OFS_SYSCFG: begin
                        r_d.autoidle = reg_wdata[0];
                        srst_req     = reg_wdata[1];
                    end
                    default: ;
                endcase
            end
            if (reg_rd && (reg_addr == OFS_INT)) r_d.ist = '0;
            if (r_q.clken && (done_tx || done_rx || done_to)) begin
                if (done_tx) r_d.ist[IB_TX] = 1'b1;
                if (done_rx) r_d.ist[IB_RX] = 1'b1;
                if (done_to) r_d.ist[IB_TO] = 1'b1;
                if (done_rx) r_d.rx = rx_byte;
                r_d.go   = 1'b0;
                r_d.init = 1'b0;
            end
            if (srst_req) begin
                r_d          = REGS_RST;
                r_d.autoidle = reg_wdata[0];
                start        = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (reg_addr)
            OFS_REV:    reg_rdata = {4'(REV_MAJOR), 4'(REV_MINOR)};
            OFS_TX:     reg_rdata = r_q.tx;
            OFS_RX:     reg_rdata = r_q.rx;
            OFS_CTRL:   reg_rdata = {1'b0, r_q.ie, r_q.clken, r_q.go, 1'b0,
                                     r_q.init, r_q.dir, r_q.mode};
            OFS_INT:    reg_rdata = {5'b0, r_q.ist};
            OFS_SYSCFG: reg_rdata = {6'b0, in_reset, r_q.autoidle};
            OFS_SYSST:  reg_rdata = {7'b0, !in_reset};
            default:    reg_rdata = 8'h00;
        endcase
    end

    assign irq     = r_q.ie && (r_q.ist != '0);
    assign tx_byte = r_q.tx;
    assign clken   = r_q.clken;
    assign clr     = in_reset;

    assert_tx_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.clken && done_tx && !in_reset && !wr_syscfg) |=> (r_q.ist[IB_TX] && !r_q.go));

    assert_busy_go_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.go || in_reset));

    assert_go_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.go) |-> r_q.clken);

    assert_int_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_INT && !done_tx && !done_rx && !done_to && !in_reset)
        |=> (r_q.ist == '0));

    assert_srst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset |-> !r_q.go);
endmodule

// File: rtl/swbus_master.sv
module swbus_master
    import swbus_pkg::*;
#(
    parameter int CLK_PER_US   = 100,
    parameter int BREAK_LOW_US = 190,
    parameter int BREAK_REC_US = 40,
    parameter int CELL_US      = 200,
    parameter int ONE_LOW_US   = 30,
    parameter int ZERO_LOW_US  = 130,
    parameter int SAMPLE_US    = 80,
    parameter int RX_WINDOW_US = 500,
    parameter int REV_MAJOR    = 1,
    parameter int REV_MINOR    = 2,
    parameter int RST_CYCLES   = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       line_in,
    output logic       line_pull
);
    logic       line_s;
    logic       start, clken, clr, busy;
    logic       done_tx, done_rx, done_to;
    logic [7:0] tx_byte, rx_byte;
    op_e        op;

    swbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_in),
        .sync_o  (line_s)
    );

    swbus_regs #(
        .REV_MAJOR  (REV_MAJOR),
        .REV_MINOR  (REV_MINOR),
        .RST_CYCLES (RST_CYCLES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .start     (start),
        .op        (op),
        .tx_byte   (tx_byte),
        .clken     (clken),
        .clr       (clr),
        .busy      (busy),
        .done_tx   (done_tx),
        .done_rx   (done_rx),
        .done_to   (done_to),
        .rx_byte   (rx_byte)
    );

    swbus_seq #(
        .CLK_PER_US   (CLK_PER_US),
        .BREAK_LOW_US (BREAK_LOW_US),
        .BREAK_REC_US (BREAK_REC_US),
        .CELL_US      (CELL_US),
        .ONE_LOW_US   (ONE_LOW_US),
        .ZERO_LOW_US  (ZERO_LOW_US),
        .SAMPLE_US    (SAMPLE_US),
        .RX_WINDOW_US (RX_WINDOW_US)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .en      (clken),
        .start   (start),
        .op      (op),
        .tx_byte (tx_byte),
        .line_s  (line_s),
        .pull    (line_pull),
        .busy    (busy),
        .done_tx (done_tx),
        .done_rx (done_rx),
        .done_to (done_to),
        .rx_byte (rx_byte)
    );
endmodule

// File: tb/sim_swbus_master.sv
module sim_swbus_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;
    logic       line_pull;
    logic       slave_low = 1'b0;
    logic       line_in;

    int nvec = 0;
    int nbad = 0;
    int widths [16];
    int nw = 0;
    int run = 0;
    bit irq_seen = 0;

    assign line_in = !(line_pull || slave_low);

    always #2 clk = ~clk;

    swbus_master #(.CLK_PER_US(1), .RST_CYCLES(8)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .line_in(line_in), .line_pull(line_pull)
    );

    always @(negedge clk) begin
        if (irq) irq_seen = 1;
        if (line_pull) run = run + 1;
        else if (run != 0) begin
            if (nw < 16) widths[nw] = run;
            nw  = nw + 1;
            run = 0;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog: actual expired expected completion");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(input int maxc, output int n);
        n = 0;
        while (!irq && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic slave_send(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            int lo;
            lo = b[i] ? 30 : 120;
            slave_low = 1'b1;
            repeat (lo) @(negedge clk);
            slave_low = 1'b0;
            repeat (200 - lo) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int d;
        rd(5'h18, d); chk("R1 sysstatus during reset count", d, 0);
        repeat (10) @(negedge clk);
        rd(5'h18, d); chk("R1 sysstatus after reset", d, 1);
        rd(5'h0C, d); chk("R1 control reset", d, 0);
        rd(5'h10, d); chk("R1 int status reset", d, 0);
        rd(5'h08, d); chk("R1 rx data reset", d, 0);
        rd(5'h04, d); chk("R1 tx data reset", d, 0);
        chk("R1 irq reset", irq, 0);
        chk("R1 line released", line_pull, 0);
        rd(5'h00, d); chk("R2 revision", d, 8'h12);
    endtask

    task automatic t_tx();
        int d, n, mn, mx;
        logic [7:0] dec;
        wr(5'h04, 8'hB4);
        nw = 0;
        wr(5'h0C, 8'h70);
        rd(5'h0C, d); chk("R3 go reads 1 while busy", d, 8'h70);
        wr(5'h0C, 8'h26);
        rd(5'h0C, d); chk("R10 control write ignored while busy", d, 8'h70);
        wait_irq(3000, n);
        chk("R8 irq after transmit", irq, 1);
        repeat (300) @(negedge clk);
        chk("R10 exactly eight pulses, no restart", nw, 8);
        dec = '0; mn = 1000; mx = 0;
        for (int i = 0; i < 8; i++) begin
            dec[i] = (widths[i] < 80);
            if (widths[i] < mn) mn = widths[i];
            if (widths[i] > mx) mx = widths[i];
        end
        chk("R3 byte sent LSB first", dec, 8'hB4);
        chk("R3 one pulse width", mn, 30);
        chk("R3 zero pulse width", mx, 130);
        rd(5'h0C, d); chk("R3 go self-clears", d, 8'h60);
        rd(5'h10, d); chk("R3 tx-complete flag", d, 8'h04);
        rd(5'h10, d); chk("R7 status cleared by read", d, 0);
        chk("R8 irq drops after clear", irq, 0);
    endtask

    task automatic t_rx();
        int d, n;
        nw = 0;
        wr(5'h0C, 8'h72);
        repeat (20) @(negedge clk);
        slave_send(8'hA5);
        wait_irq(1000, n);
        chk("R4 irq after receive", irq, 1);
        rd(5'h10, d); chk("R4 rx-complete flag", d, 8'h02);
        rd(5'h08, d); chk("R4 received byte", d, 8'hA5);
        rd(5'h0C, d); chk("R4 go self-clears", d, 8'h62);
        chk("R4 no master pull during receive", nw, 0);
    endtask

    task automatic t_timeout();
        int d, n;
        wr(5'h0C, 8'h72);
        repeat (450) @(negedge clk);
        chk("R5 no timeout before window", irq, 0);
        wait_irq(200, n);
        chk("R5 timeout irq", irq, 1);
        rd(5'h10, d); chk("R5 timeout flag only", d, 8'h01);
        rd(5'h0C, d); chk("R5 go self-clears", d, 8'h62);
    endtask

    task automatic t_break();
        int d, lo, n;
        wr(5'h0C, 8'h74);
        lo = 0;
        while (!line_pull) @(negedge clk);
        while (line_pull) begin @(negedge clk); lo++; end
        chk("R6 break low width", lo, 190);
        wait_irq(200, n);
        chk("R6 recovery before flag", (n >= 39 && n <= 41), 1);
        rd(5'h10, d); chk("R6 break sets timeout flag", d, 8'h01);
        rd(5'h0C, d); chk("R6 init and go clear", d, 8'h60);
    endtask

    task automatic t_ie_off();
        int d;
        wr(5'h04, 8'h01);
        irq_seen = 0;
        wr(5'h0C, 8'h30);
        d = 8'h10;
        for (int k = 0; k < 60 && d[4]; k++) begin
            repeat (50) @(negedge clk);
            rd(5'h0C, d);
        end
        chk("R8 transfer ended", d, 8'h20);
        chk("R8 irq held low without enable", irq_seen, 0);
        rd(5'h10, d); chk("R8 status still recorded", d, 8'h04);
    endtask

    task automatic t_clken_off();
        int d;
        nw = 0;
        wr(5'h0C, 8'h50);
        rd(5'h0C, d); chk("R9 go not set without clock enable", d, 8'h40);
        repeat (300) @(negedge clk);
        chk("R9 line untouched", nw, 0);
        rd(5'h10, d); chk("R9 no status", d, 0);
    endtask

    task automatic t_softreset();
        int d, k;
        wr(5'h04, 8'hFF);
        wr(5'h0C, 8'h70);
        repeat (100) @(negedge clk);
        wr(5'h14, 8'h03);
        rd(5'h18, d); chk("R11 sysstatus low during soft reset", d, 0);
        rd(5'h14, d); chk("R11 soft reset bit reads 1", d, 8'h03);
        repeat (12) @(negedge clk);
        rd(5'h18, d); chk("R11 reset done", d, 1);
        rd(5'h14, d); chk("R11 soft reset bit clears", d, 8'h01);
        rd(5'h0C, d); chk("R11 control cleared", d, 0);
        rd(5'h04, d); chk("R11 tx cleared", d, 0);
        rd(5'h08, d); chk("R11 rx cleared", d, 0);
        rd(5'h10, d); chk("R11 status cleared", d, 0);
        chk("R11 line released", line_pull, 0);
        k = nw;
        repeat (300) @(negedge clk);
        chk("R11 transfer stopped", nw, k);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tx();
        t_rx();
        t_timeout();
        t_break();
        t_ie_off();
        t_clken_off();
        t_softreset();
        summary();
        $finish;
    end
endmodule